// File: doc/BRIEF.md
# Prescaled Alarm Timer Group

This block holds two independent 64-bit general-purpose timers and one shared interrupt unit, all reached through a plain word-addressed write/read port. Each timer has its own clock prescaler, an up or down count direction, a run control, a 64-bit alarm compare and a 64-bit reload register. When the count equals the alarm value while the alarm is armed, the timer raises its status bit and disarms itself. With auto-reload selected, the same event also copies the reload register into the counter, which gives periodic events once software re-arms the alarm.

Software sets the count by writing the reload register and issuing a load command. It reads the count by issuing a latch command and then reading two snapshot words, which always come from the same clock cycle. The interrupt unit keeps a raw status bit per source: bit 0 for timer 0, bit 1 for timer 1 and bit 2 for an external watchdog event pulse. Each bit has an enable and a write-1-to-clear control. A single level output is high while any enabled status bit is set.

Register map (word addresses, 5-bit address): timer t occupies 8*t+0..8*t+7 with offset 0 control (bit 0 run, bit 1 up when 1 and down when 0, bit 2 auto-reload, bit 3 alarm armed), offset 1 divide field (16 bits), offsets 2/3 alarm low/high words, offsets 4/5 reload low/high words, offset 6 a command on write (bit 0 latch snapshot, bit 1 load counter from reload) and snapshot low word on read, offset 7 snapshot high word. The group unit sits at 0x10 enable, 0x11 raw status, 0x12 clear (write only, reads 0), 0x13 enabled status (raw AND enable).

Top module: `tgrp_top`

## Requirements
- R1: A command write with bit 1 set copies the 64-bit reload register into the counter; a command write with bit 0 set copies the counter into the snapshot, whose low and high words (offsets 6 and 7) then read from the same cycle and stay unchanged until the next latch.
- R2: Divide field value N gives a ratio of N for 2..65535, value 1 gives a ratio of 2 and value 0 gives 65536; while running the counter moves by one every ratio clock cycles, never on two consecutive cycles.
- R3: Control bit 1 set counts up, clear counts down; the count wraps modulo 2^64 in both directions.
- R4: Control bit 0 runs the timer; while it is clear the count and the prescale phase hold, and counting resumes from the held phase.
- R5: While control bit 3 is set and the count equals the 64-bit alarm value, the timer's raw status bit (bit t for timer t) is set at the next clock edge.
- R6: An alarm event clears control bit 3 at the same edge, unless software writes the control register in that cycle.
- R7: With control bit 2 set, an alarm event loads the reload register into the counter at that edge instead of counting; a software load in the same cycle has priority.
- R8: Raw status bit 2 is set by a one-cycle watchdog event pulse; writing 1 to a bit of the clear register drops that raw bit; the enabled-status register reads raw AND enable.
- R9: The interrupt output is a level that is high exactly while some raw status bit has its enable bit set.
- R10: Any write to a timer's divide field restarts its prescale phase from zero, so no partial tick carries over.
- R11: A write to the divide field is stored as its low 16 bits, and a control write stores only bits 3:0; alarm, reload and enable registers read back what was written (enable as 3 bits).
- R12: After reset all control bits, counters, snapshots, status and enables are zero, the divide field reads 2 and the interrupt output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 5 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register (combinational) |
| wdt_evt | input | 1 | Watchdog event pulse, sets raw status bit 2 |
| irq_out | output | 1 | Level interrupt request |

## Verification
On every cycle the assertions check that prescaler ticks are never adjacent, that a paused timer's count is frozen, that a tick moves the count by exactly one in the selected direction, that an alarm hit sets the raw status, disarms the alarm and, with auto-reload, loads the reload value. Only the bench scenarios can show the absolute tick rate for each divide field including the 0 and 1 encodings, the phase restart on a divide write, wrap-around at both ends of the 64-bit range, snapshot coherence, the interrupt enable and clear path, the watchdog bit and the register readback widths.

// File: rtl/tgrp_pkg.sv
package tgrp_pkg;
  localparam int NT     = 2;
  localparam int CW     = 64;
  localparam int DW     = 32;
  localparam int PW     = 16;
  localparam int AW     = 5;
  localparam int NSRC   = NT + 1;
  localparam int NREG   = 8;

  localparam logic [2:0] OFF_CTRL = 3'd0;
  localparam logic [2:0] OFF_DIV  = 3'd1;
  localparam logic [2:0] OFF_ALO  = 3'd2;
  localparam logic [2:0] OFF_AHI  = 3'd3;
  localparam logic [2:0] OFF_RLO  = 3'd4;
  localparam logic [2:0] OFF_RHI  = 3'd5;
  localparam logic [2:0] OFF_CMD  = 3'd6;
  localparam logic [2:0] OFF_SHI  = 3'd7;

  localparam logic [1:0] G_EN  = 2'd0;
  localparam logic [1:0] G_RAW = 2'd1;
  localparam logic [1:0] G_CLR = 2'd2;
  localparam logic [1:0] G_ST  = 2'd3;

  typedef struct packed {
    logic aen;
    logic ar;
    logic up;
    logic run;
  } ctrl_t;

  // Terminal value of the prescale phase counter for a divide field.
  function automatic logic [PW-1:0] div_limit(input logic [PW-1:0] f);
    if (f == '0)                 return '1;
    else if (f == {{(PW-1){1'b0}}, 1'b1}) return {{(PW-1){1'b0}}, 1'b1};
    else                         return f - 1'b1;
  endfunction

  function automatic logic [CW-1:0] count_step(input logic [CW-1:0] c, input logic up);
    return up ? c + 1'b1 : c - 1'b1;
  endfunction
endpackage

// File: rtl/tgrp_presc.sv
module tgrp_presc
  import tgrp_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          restart,
  input  logic [PW-1:0] field,
  output logic          tick
);
  logic [PW-1:0] phase_q;
  logic [PW-1:0] lim;

  assign lim  = div_limit(field);
  assign tick = run && (phase_q == lim);

  always_ff @(posedge clk) begin
    if (!rst_n)       phase_q <= '0;
    else if (restart) phase_q <= '0;
    else if (run)     phase_q <= (phase_q == lim) ? '0 : phase_q + 1'b1;
  end
endmodule

// File: rtl/tgrp_chan.sv
module tgrp_chan
  import tgrp_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NREG-1:0] wr_sel,
  input  logic [DW-1:0]   wdata,
  output ctrl_t           ctrl_o,
  output logic [PW-1:0]   div_o,
  output logic [CW-1:0]   alarm_o,
  output logic [CW-1:0]   reload_o,
  output logic [CW-1:0]   cnt_o,
  output logic [CW-1:0]   snap_o,
  output logic            tick_o,
  output logic            hit_o,
  output logic            load_o
);
  ctrl_t         ctrl_q;
  logic [PW-1:0] div_q;
  logic [CW-1:0] alarm_q, reload_q, cnt_q, snap_q;
  logic          latch, tick;

  assign load_o = wr_sel[OFF_CMD] && wdata[1];
  assign latch  = wr_sel[OFF_CMD] && wdata[0];
  assign hit_o  = ctrl_q.aen && (cnt_q == alarm_q);

  tgrp_presc u_presc (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (ctrl_q.run),
    .restart (wr_sel[OFF_DIV]),
    .field   (div_q),
    .tick    (tick)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      div_q    <= PW'(2);
      alarm_q  <= '0;
      reload_q <= '0;
    end else begin
      if (wr_sel[OFF_CTRL])  ctrl_q <= ctrl_t'(wdata[3:0]);
      else if (hit_o)        ctrl_q.aen <= 1'b0;
      if (wr_sel[OFF_DIV])   div_q <= wdata[PW-1:0];
      if (wr_sel[OFF_ALO])   alarm_q[DW-1:0]   <= wdata;
      if (wr_sel[OFF_AHI])   alarm_q[CW-1:DW]  <= wdata;
      if (wr_sel[OFF_RLO])   reload_q[DW-1:0]  <= wdata;
      if (wr_sel[OFF_RHI])   reload_q[CW-1:DW] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                    cnt_q <= '0;
    else if (load_o)               cnt_q <= reload_q;
    else if (hit_o && ctrl_q.ar)   cnt_q <= reload_q;
    else if (tick)                 cnt_q <= count_step(cnt_q, ctrl_q.up);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     snap_q <= '0;
    else if (latch) snap_q <= cnt_q;
  end

  assign ctrl_o   = ctrl_q;
  assign div_o    = div_q;
  assign alarm_o  = alarm_q;
  assign reload_o = reload_q;
  assign cnt_o    = cnt_q;
  assign snap_o   = snap_q;
  assign tick_o   = tick;
endmodule

// File: rtl/tgrp_irq.sv
module tgrp_irq
  import tgrp_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set,
  input  logic            en_wr,
  input  logic            clr_wr,
  input  logic [NSRC-1:0] wbits,
  output logic [NSRC-1:0] en_o,
  output logic [NSRC-1:0] raw_o,
  output logic            irq
);
  logic [NSRC-1:0] en_q, raw_q, clr;

  assign clr = clr_wr ? wbits : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= '0;
      raw_q <= '0;
    end else begin
      if (en_wr) en_q <= wbits;
      raw_q <= (raw_q & ~clr) | set;
    end
  end

  assign irq   = |(raw_q & en_q);
  assign en_o  = en_q;
  assign raw_o = raw_q;
endmodule

// File: rtl/tgrp_top.sv
module tgrp_top
  import tgrp_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          wdt_evt,
  output logic          irq_out
);
  logic            is_grp;
  logic [2:0]      off;
  logic [1:0]      goff;

  ctrl_t           ctrl_w   [NT];
  logic [PW-1:0]   div_w    [NT];
  logic [CW-1:0]   alarm_w  [NT];
  logic [NT-1:0][CW-1:0] cnt_w, rld_w, snap_w;
  logic [NT-1:0]   tick_w, hit_w, load_w, ctrl_wr_w;
  logic [NT-1:0]   run_w, up_w, ar_w, aen_w;
  logic [NSRC-1:0] en_w, raw_w;

  assign is_grp = bus_addr[4];
  assign off    = bus_addr[2:0];
  assign goff   = bus_addr[1:0];

  for (genvar t = 0; t < NT; t++) begin : g_chan
    logic [NREG-1:0] sel;
    assign sel = (bus_we && !is_grp && (int'(bus_addr[3]) == t)) ? (NREG'(1) << off) : '0;
    assign ctrl_wr_w[t] = sel[OFF_CTRL];

    tgrp_chan u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_sel   (sel),
      .wdata    (bus_wdata),
      .ctrl_o   (ctrl_w[t]),
      .div_o    (div_w[t]),
      .alarm_o  (alarm_w[t]),
      .reload_o (rld_w[t]),
      .cnt_o    (cnt_w[t]),
      .snap_o   (snap_w[t]),
      .tick_o   (tick_w[t]),
      .hit_o    (hit_w[t]),
      .load_o   (load_w[t])
    );

    assign run_w[t] = ctrl_w[t].run;
    assign up_w[t]  = ctrl_w[t].up;
    assign ar_w[t]  = ctrl_w[t].ar;
    assign aen_w[t] = ctrl_w[t].aen;
  end

  tgrp_irq u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .set    ({wdt_evt, hit_w}),
    .en_wr  (bus_we && is_grp && goff == G_EN),
    .clr_wr (bus_we && is_grp && goff == G_CLR),
    .wbits  (bus_wdata[NSRC-1:0]),
    .en_o   (en_w),
    .raw_o  (raw_w),
    .irq    (irq_out)
  );

  always_comb begin
    int ti;
    ti = int'(bus_addr[3]);
    bus_rdata = '0;
    if (is_grp) begin
      case (goff)
        G_EN:    bus_rdata = DW'(en_w);
        G_RAW:   bus_rdata = DW'(raw_w);
        G_ST:    bus_rdata = DW'(raw_w & en_w);
        default: bus_rdata = '0;
      endcase
    end else begin
      case (off)
        OFF_CTRL: bus_rdata = DW'(ctrl_w[ti]);
        OFF_DIV:  bus_rdata = DW'(div_w[ti]);
        OFF_ALO:  bus_rdata = alarm_w[ti][DW-1:0];
        OFF_AHI:  bus_rdata = alarm_w[ti][CW-1:DW];
        OFF_RLO:  bus_rdata = rld_w[ti][DW-1:0];
        OFF_RHI:  bus_rdata = rld_w[ti][CW-1:DW];
        OFF_CMD:  bus_rdata = snap_w[ti][DW-1:0];
        default:  bus_rdata = snap_w[ti][CW-1:DW];
      endcase
    end
  end
endmodule

// File: rtl/tgrp_chk.sv
module tgrp_chk
  import tgrp_pkg::*;
(
  input logic                  clk,
  input logic                  rst_n,
  input logic [NT-1:0]         tick,
  input logic [NT-1:0]         hit,
  input logic [NT-1:0]         load,
  input logic [NT-1:0]         ctrl_wr,
  input logic [NT-1:0]         run,
  input logic [NT-1:0]         up,
  input logic [NT-1:0]         ar,
  input logic [NT-1:0]         aen,
  input logic [NT-1:0][CW-1:0] cnt,
  input logic [NT-1:0][CW-1:0] rld,
  input logic [NSRC-1:0]       raw
);
  for (genvar i = 0; i < NT; i++) begin : g_chk
    // R2
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick[i] |=> !tick[i]);
    // R4
    pause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run[i] && !load[i] && !hit[i]) |=> $stable(cnt[i]));
    // R3
    up_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick[i] && up[i] && !load[i] && !(hit[i] && ar[i])) |=> cnt[i] == $past(cnt[i]) + 64'd1);
    // R3
    down_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick[i] && !up[i] && !load[i] && !(hit[i] && ar[i])) |=> cnt[i] == $past(cnt[i]) - 64'd1);
    // R5
    hit_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit[i] |=> raw[i]);
    // R6
    disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit[i] && !ctrl_wr[i]) |=> !aen[i]);
    // R7
    auto_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit[i] && ar[i] && !load[i]) |=> cnt[i] == $past(rld[i]));
  end
endmodule

bind tgrp_top tgrp_chk u_tgrp_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .tick    (tick_w),
  .hit     (hit_w),
  .load    (load_w),
  .ctrl_wr (ctrl_wr_w),
  .run     (run_w),
  .up      (up_w),
  .ar      (ar_w),
  .aen     (aen_w),
  .cnt     (cnt_w),
  .rld     (rld_w),
  .raw     (raw_w)
);

// File: tb/test_tgrp_top.sv
module test_tgrp_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        wdt_evt = 1'b0;
  logic        irq_out;

  int nvec = 0;
  int nbad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tgrp_top i_tgrp_top (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wdt_evt(wdt_evt), .irq_out(irq_out)
  );

  // {address, write data, expected readback}; R11 register widths
  localparam int NV = 13;
  localparam logic [68:0] VEC [NV] = '{
    {5'h02, 32'hDEADBEEF, 32'hDEADBEEF},
    {5'h03, 32'h01234567, 32'h01234567},
    {5'h04, 32'h0BADF00D, 32'h0BADF00D},
    {5'h05, 32'hCAFEF00D, 32'hCAFEF00D},
    {5'h01, 32'h00012345, 32'h00002345},
    {5'h09, 32'hFFFF0003, 32'h00000003},
    {5'h0A, 32'h55AA55AA, 32'h55AA55AA},
    {5'h10, 32'hFFFFFFFF, 32'h00000007},
    {5'h10, 32'h00000000, 32'h00000000},
    {5'h00, 32'h00000030, 32'h00000000},
    {5'h08, 32'h00000002, 32'h00000002},
    {5'h08, 32'h00000000, 32'h00000000},
    {5'h12, 32'h0000000F, 32'h00000000}
  };

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    nvec++;
    if (got !== exp) begin
      nbad++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a;
    #1 v = bus_rdata;
  endtask

  task automatic load64(input int t, input logic [63:0] v);
    wr(5'(t*8 + 4), v[31:0]);
    wr(5'(t*8 + 5), v[63:32]);
    wr(5'(t*8 + 6), 32'h2);
  endtask

  task automatic snap(input int t, output logic [63:0] v);
    logic [31:0] lo, hi;
    wr(5'(t*8 + 6), 32'h1);
    rd(5'(t*8 + 6), lo);
    rd(5'(t*8 + 7), hi);
    v = {hi, lo};
  endtask

  // run for n+1 counting edges: start write, n idle edges, stop write
  task automatic run_for(input int t, input logic [31:0] cstart, input logic [31:0] cstop, input int n);
    wr(5'(t*8), cstart);
    repeat (n) @(negedge clk);
    bus_we = 1'b1; bus_addr = 5'(t*8); bus_wdata = cstop;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog got hung exp finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [63:0] c;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R12 reset state
    #1 chk("R12 irq_out", 64'(irq_out), 64'd0);
    rd(5'h00, v); chk("R12 ctrl", 64'(v), 64'd0);
    rd(5'h01, v); chk("R12 div", 64'(v), 64'd2);
    rd(5'h11, v); chk("R12 raw", 64'(v), 64'd0);
    rd(5'h0E, v); chk("R12 snap", 64'(v), 64'd0);

    // R11 register table
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][68:64], VEC[i][63:32]);
      rd(VEC[i][68:64], v);
      chk($sformatf("R11 vector %0d", i), 64'(v), 64'(VEC[i][31:0]));
    end

    // R2 ratio 4, 40 edges -> 10; R4 pause hold
    wr(5'h01, 32'd4); load64(0, 64'd0);
    run_for(0, 32'h3, 32'h2, 39);
    snap(0, c); chk("R2 ratio4 count", c, 64'd10);
    repeat (20) @(negedge clk);
    snap(0, c); chk("R4 paused hold", c, 64'd10);

    // R10 divide write restarts phase
    wr(5'h01, 32'd4); load64(0, 64'd0);
    run_for(0, 32'h3, 32'h2, 2);
    snap(0, c); chk("R4 partial phase", c, 64'd0);
    wr(5'h01, 32'd4);
    run_for(0, 32'h3, 32'h2, 0);
    snap(0, c); chk("R10 phase restart", c, 64'd0);

    // R3 down count and wraps
    wr(5'h01, 32'd2); load64(0, 64'd5);
    run_for(0, 32'h1, 32'h0, 5);
    snap(0, c); chk("R3 down count", c, 64'd2);
    wr(5'h01, 32'd2); load64(0, 64'hFFFF_FFFF_FFFF_FFFF);
    run_for(0, 32'h3, 32'h2, 1);
    snap(0, c); chk("R3 up wrap", c, 64'd0);
    wr(5'h01, 32'd2); load64(0, 64'd0);
    run_for(0, 32'h1, 32'h0, 1);
    snap(0, c); chk("R3 down wrap", c, 64'hFFFF_FFFF_FFFF_FFFF);

    // R2 field 1 is ratio 2
    wr(5'h01, 32'd1); load64(0, 64'd0);
    run_for(0, 32'h3, 32'h2, 1);
    snap(0, c); chk("R2 field1", c, 64'd1);

    // R2 field 0 is ratio 65536
    wr(5'h01, 32'd0); load64(0, 64'd0);
    run_for(0, 32'h3, 32'h2, 65534);
    snap(0, c); chk("R2 field0 before", c, 64'd0);
    run_for(0, 32'h3, 32'h2, 0);
    snap(0, c); chk("R2 field0 at 65536", c, 64'd1);

    // R1 load and coherent snapshot
    load64(0, 64'h0000_0001_FFFF_FFFF);
    snap(0, c); chk("R1 snapshot", c, 64'h0000_0001_FFFF_FFFF);
    load64(0, 64'd7);
    rd(5'h06, v); chk("R1 snapshot held", 64'(v), 64'hFFFF_FFFF);

    // R5 R6 R8 R9 single alarm, no reload
    wr(5'h12, 32'h7); wr(5'h10, 32'h0);
    wr(5'h01, 32'd2); load64(0, 64'd0);
    wr(5'h02, 32'd5); wr(5'h03, 32'd0);
    wr(5'h00, 32'hB);
    repeat (30) @(negedge clk);
    rd(5'h00, v); chk("R6 disarmed", 64'(v), 64'h3);
    rd(5'h11, v); chk("R5 raw bit0", 64'(v), 64'h1);
    chk("R9 masked", 64'(irq_out), 64'd0);
    wr(5'h00, 32'h2);
    wr(5'h10, 32'h1);
    #1 chk("R9 irq high", 64'(irq_out), 64'd1);
    rd(5'h13, v); chk("R8 enabled status", 64'(v), 64'h1);
    wr(5'h12, 32'h1);
    #1 chk("R9 irq cleared", 64'(irq_out), 64'd0);
    rd(5'h11, v); chk("R8 clear", 64'(v), 64'h0);

    // R7 auto-reload: ratio 2, alarm 3, 21 edges -> 7
    wr(5'h01, 32'd2); load64(0, 64'd0);
    wr(5'h02, 32'd3); wr(5'h03, 32'd0);
    run_for(0, 32'hF, 32'h6, 20);
    snap(0, c); chk("R7 reloaded count", c, 64'd7);
    rd(5'h11, v); chk("R7 raw bit0", 64'(v), 64'h1);
    wr(5'h12, 32'h1);

    // R5 timer 1 maps to bit 1
    load64(1, 64'd0);
    wr(5'h0A, 32'd0); wr(5'h0B, 32'd0);
    wr(5'h08, 32'h8);
    repeat (3) @(negedge clk);
    rd(5'h11, v); chk("R5 raw bit1", 64'(v), 64'h2);
    wr(5'h12, 32'h2);

    // R8 watchdog bit
    @(negedge clk) wdt_evt = 1'b1;
    @(negedge clk) wdt_evt = 1'b0;
    rd(5'h11, v); chk("R8 watchdog raw", 64'(v), 64'h4);
    wr(5'h10, 32'h4);
    #1 chk("R9 watchdog irq", 64'(irq_out), 64'd1);
    wr(5'h12, 32'h4);
    rd(5'h11, v); chk("R8 watchdog clear", 64'(v), 64'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule